// File: doc/BRIEF.md
# Shared-Datapath Integer ALU

This block is a purely combinational 32-bit arithmetic and logic unit for an integer execution stage. Each cycle it takes two operands, a 4-bit operation code and a 5-bit shift count. It returns a 32-bit result and one overflow flag. It covers addition, subtraction, three kinds of shift, four bitwise functions and four set-style tests.

The datapath has exactly one adder and exactly one shifter. Both are shared by every operation, and their controls are decoded from the operation code. Subtraction reuses the adder: it inverts the second operand and forces the carry-in to one. The equality tests read the adder's difference. Right shifts reuse the left-shift network: the operand is bit-reversed on the way in and the result is bit-reversed on the way out. A final selector picks one candidate result. All sixteen operation codes are defined.

Top module: `alu32`

## Requirements
- R1: Codes 0110 and 0111 give c_o = a_i + b_i modulo 2^32. v_o is 1 exactly when both operands have the same sign bit and the sum's sign bit differs from it.
- R2: Codes 1010 and 1011 give c_o = a_i - b_i modulo 2^32. v_o is 1 exactly when the operand sign bits differ and the result's sign bit differs from a_i[31].
- R3: When v_o is 1, c_o still holds the wrapped 32-bit sum or difference.
- R4: Codes 1000 and 1001 shift b_i left by sa_i places (0 to 31) and fill with zeros.
- R5: Code 1100 shifts b_i right by sa_i places and fills with zeros.
- R6: Code 1101 shifts b_i right by sa_i places and fills with copies of b_i[31].
- R7: Code 0010 gives a_i AND b_i, 0011 gives OR, 0100 gives XOR and 0101 gives NOR.
- R8: Code 0000 gives 1 when a_i differs from b_i and 0 otherwise. Code 0001 gives 1 when they are equal.
- R9: Code 1110 gives 1 when a_i, read as signed, is less than or equal to zero. Code 1111 gives 1 when a_i is greater than zero. Neither depends on b_i.
- R10: For codes 0000, 0001, 1110 and 1111, bits 31 to 1 of c_o are zero.
- R11: v_o is 0 for every code other than 0110, 0111, 1010 and 1011.
- R12: The low bit of codes 011x, 100x and 101x has no effect on c_o or v_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; it is also the shifted value |
| op_i | input | 4 | Operation code |
| sa_i | input | 5 | Shift count, unsigned |
| c_o | output | 32 | Result |
| v_o | output | 1 | Two's-complement overflow for add and subtract |

## Verification
The in-line checks assume that every input is a known 0/1 value and that inputs change only between evaluations, so each check sees a settled datapath. The bench changes inputs only on the falling clock edge and reads the outputs one nanosecond after the rising edge. It sweeps all sixteen codes over a fixed set of signed extremes and bit patterns, with shift counts at 0, 1, a middle value and 31. A pseudo-random pass then covers every count.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        SRC_ADD,
        SRC_SHIFT,
        SRC_AND,
        SRC_OR,
        SRC_XOR,
        SRC_NOR,
        SRC_SET
    } src_e;

    typedef enum logic [1:0] {
        TST_NE,
        TST_EQ,
        TST_LEZ,
        TST_GTZ
    } tst_e;

    typedef struct packed {
        src_e src;
        tst_e tst;
        logic sub;
        logic shr;
        logic sra;
        logic ovf_en;
    } ctl_t;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);
    logic [W-2:0] low_d;
    logic         cmsb_d;
    logic         cout_d;
    logic         smsb_d;

    always_comb begin
        {cmsb_d, low_d} = {1'b0, a_i[W-2:0]} + {1'b0, b_i[W-2:0]} + {{(W-1){1'b0}}, cin_i};
        {cout_d, smsb_d} = {1'b0, a_i[W-1]} + {1'b0, b_i[W-1]} + {1'b0, cmsb_d};
        sum_o = {smsb_d, low_d};
        ovf_o = cmsb_d ^ cout_d;
    end

    // R3: overflow agrees with the sign rule on the operands the adder sees
    always_comb begin
        sign_rule_chk: assert (ovf_o == ((a_i[W-1] == b_i[W-1]) && (sum_o[W-1] != a_i[W-1])))
            else $error("adder overflow disagrees with sign rule");
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W   = 32,
    parameter int SAW = $clog2(W)
) (
    input  logic [W-1:0]   val_i,
    input  logic [SAW-1:0] amt_i,
    input  logic           right_i,
    input  logic           fill_i,
    output logic [W-1:0]   res_o
);
    logic [W-1:0] stg [0:SAW];
    logic [W-1:0] out_d;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            stg[0][i] = right_i ? val_i[W-1-i] : val_i[i];
        end
    end

    for (genvar k = 0; k < SAW; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign stg[k+1] = amt_i[k] ? {stg[k][W-1-SH:0], {SH{fill_i}}} : stg[k];
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            out_d[i] = right_i ? stg[SAW][W-1-i] : stg[SAW][i];
        end
        res_o = out_d;
    end

    // R4: a zero count passes the value through unchanged
    always_comb begin
        if (amt_i == '0) begin
            zero_count_chk: assert (res_o == val_i)
                else $error("zero shift count altered the value");
        end
    end
endmodule

// File: rtl/alu32.sv
module alu32
    import alu_pkg::*;
#(
    parameter int W   = 32,
    parameter int SAW = $clog2(W)
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [3:0]     op_i,
    input  logic [SAW-1:0] sa_i,
    output logic [W-1:0]   c_o,
    output logic           v_o
);
    ctl_t         ctl_d;
    logic [W-1:0] addb_d;
    logic [W-1:0] sum_d;
    logic         ovf_d;
    logic [W-1:0] shf_d;
    logic         bit_d;
    logic [W-1:0] res_d;

    always_comb begin
        ctl_d = '{src: SRC_SET, tst: TST_NE, sub: 1'b1, shr: 1'b0, sra: 1'b0, ovf_en: 1'b0};
        unique casez (op_i)
            4'b0000: ctl_d.tst = TST_NE;
            4'b0001: ctl_d.tst = TST_EQ;
            4'b0010: ctl_d.src = SRC_AND;
            4'b0011: ctl_d.src = SRC_OR;
            4'b0100: ctl_d.src = SRC_XOR;
            4'b0101: ctl_d.src = SRC_NOR;
            4'b011?: begin ctl_d.src = SRC_ADD; ctl_d.sub = 1'b0; ctl_d.ovf_en = 1'b1; end
            4'b100?: ctl_d.src = SRC_SHIFT;
            4'b101?: begin ctl_d.src = SRC_ADD; ctl_d.ovf_en = 1'b1; end
            4'b1100: begin ctl_d.src = SRC_SHIFT; ctl_d.shr = 1'b1; end
            4'b1101: begin ctl_d.src = SRC_SHIFT; ctl_d.shr = 1'b1; ctl_d.sra = 1'b1; end
            4'b1110: ctl_d.tst = TST_LEZ;
            default: ctl_d.tst = TST_GTZ;
        endcase
        addb_d = ctl_d.sub ? ~b_i : b_i;
    end

    alu_adder #(.W(W)) u_add (
        .a_i   (a_i),
        .b_i   (addb_d),
        .cin_i (ctl_d.sub),
        .sum_o (sum_d),
        .ovf_o (ovf_d)
    );

    alu_shifter #(.W(W), .SAW(SAW)) u_shf (
        .val_i   (b_i),
        .amt_i   (sa_i),
        .right_i (ctl_d.shr),
        .fill_i  (ctl_d.sra & b_i[W-1]),
        .res_o   (shf_d)
    );

    always_comb begin
        unique case (ctl_d.tst)
            TST_NE:  bit_d = |sum_d;
            TST_EQ:  bit_d = ~|sum_d;
            TST_LEZ: bit_d = a_i[W-1] | ~|a_i;
            default: bit_d = ~a_i[W-1] & |a_i;
        endcase
        unique case (ctl_d.src)
            SRC_ADD:   res_d = sum_d;
            SRC_SHIFT: res_d = shf_d;
            SRC_AND:   res_d = a_i & b_i;
            SRC_OR:    res_d = a_i | b_i;
            SRC_XOR:   res_d = a_i ^ b_i;
            SRC_NOR:   res_d = ~(a_i | b_i);
            default:   res_d = {{(W-1){1'b0}}, bit_d};
        endcase
        c_o = res_d;
        v_o = ovf_d & ctl_d.ovf_en;
    end

    always_comb begin
        // R11
        if (op_i[3:1] != 3'b011 && op_i[3:1] != 3'b101) begin
            no_overflow_chk: assert (!v_o) else $error("overflow on non-arithmetic code");
        end
        // R10
        if (op_i[3:1] == 3'b000 || op_i[3:1] == 3'b111) begin
            set_upper_chk: assert (c_o[W-1:1] == '0) else $error("set result has upper bits");
        end
        // R8
        if (op_i == 4'b0001) begin
            eq_test_chk: assert (c_o[0] == (a_i == b_i)) else $error("equality result wrong");
        end
        // R9
        if (op_i == 4'b1111) begin
            gtz_test_chk: assert (c_o[0] == ($signed(a_i) > 0)) else $error("gtz result wrong");
        end
    end
endmodule

// File: tb/sim_alu32.sv
module sim_alu32;
    logic        clk = 1'b0;
    logic [31:0] a, b, c;
    logic [3:0]  op;
    logic [4:0]  sa;
    logic        v;
    int          n_vec = 0;
    int          n_bad = 0;
    int          cyc = 0;
    bit          fin = 0;

    always #2.5 clk = ~clk;

    alu32 u0 (.a_i(a), .b_i(b), .op_i(op), .sa_i(sa), .c_o(c), .v_o(v));

    function automatic string tag(input logic [3:0] o);
        case (o)
            4'b0110, 4'b0111: return "R1/R3/R12";
            4'b1010, 4'b1011: return "R2/R3/R12";
            4'b1000, 4'b1001: return "R4/R11/R12";
            4'b1100:          return "R5/R11";
            4'b1101:          return "R6/R11";
            4'b0000, 4'b0001: return "R8/R10/R11";
            4'b1110, 4'b1111: return "R9/R10/R11";
            default:          return "R7/R11";
        endcase
    endfunction

    task automatic model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                         input logic [4:0] s, output logic [31:0] ec, output logic ev);
        ev = 1'b0;
        case (o)
            4'b0000: ec = {31'd0, x != y};
            4'b0001: ec = {31'd0, x == y};
            4'b0010: ec = x & y;
            4'b0011: ec = x | y;
            4'b0100: ec = x ^ y;
            4'b0101: ec = ~(x | y);
            4'b0110, 4'b0111: begin
                ec = x + y;
                ev = (x[31] == y[31]) && (ec[31] != x[31]);
            end
            4'b1000, 4'b1001: ec = y << s;
            4'b1010, 4'b1011: begin
                ec = x - y;
                ev = (x[31] != y[31]) && (ec[31] != x[31]);
            end
            4'b1100: ec = y >> s;
            4'b1101: ec = $unsigned($signed(y) >>> s);
            4'b1110: ec = {31'd0, $signed(x) <= 0};
            default: ec = {31'd0, $signed(x) > 0};
        endcase
    endtask

    task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                         input logic [4:0] s);
        logic [31:0] ec;
        logic        ev;
        @(negedge clk);
        op = o; a = x; b = y; sa = s;
        @(posedge clk);
        #1;
        model(o, x, y, s, ec, ev);
        n_vec++;
        if (c !== ec || v !== ev) begin
            n_bad++;
            $display("FAIL %s op=%b a=%h b=%h sa=%0d: got c=%h v=%b, expected c=%h v=%b",
                     tag(o), o, x, y, s, c, v, ec, ev);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !fin) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] pat [0:9];
        logic [4:0]  cnt [0:3];
        logic [31:0] lf;
        pat[0] = 32'h0000_0000; pat[1] = 32'h0000_0001; pat[2] = 32'hFFFF_FFFF;
        pat[3] = 32'h7FFF_FFFF; pat[4] = 32'h8000_0000; pat[5] = 32'h8000_0001;
        pat[6] = 32'hA5A5_5A5A; pat[7] = 32'h0F0F_F0F0; pat[8] = 32'hFFFF_FFFE;
        pat[9] = 32'h4000_0000;
        cnt[0] = 5'd0; cnt[1] = 5'd1; cnt[2] = 5'd13; cnt[3] = 5'd31;
        op = 4'd0; a = '0; b = '0; sa = '0;
        // idle state: code 0000 with equal zero operands gives zero, no overflow (R8, R11)
        apply(4'b0000, 32'd0, 32'd0, 5'd0);
        // sweep every code over signed extremes and patterns (R1..R12)
        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    for (int k = 0; k < 4; k++)
                        apply(o[3:0], pat[i], pat[j], cnt[k]);
        // every shift count on shift codes (R4, R5, R6)
        for (int s = 0; s < 32; s++) begin
            apply(4'b1000, 32'hDEAD_BEEF, 32'h8000_0001, s[4:0]);
            apply(4'b1100, 32'd0, 32'h8000_0001, s[4:0]);
            apply(4'b1101, 32'd0, 32'h8000_0001, s[4:0]);
            apply(4'b1101, 32'd0, 32'h4000_0001, s[4:0]);
        end
        // pseudo-random pass across all codes
        lf = 32'h1234_5678;
        for (int r = 0; r < 3000; r++) begin
            logic [31:0] x, y;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            x = lf ^ (lf << 7);
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            y = (r % 5 == 0) ? x : lf * 32'h9E37_79B9;
            apply(lf[3:0], x, y, lf[8:4]);
        end
        fin = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule